// File: doc/BRIEF.md
# Bus Address Trigger Evaluator

This block watches every bus cycle of a processor (address, data byte, read/write direction and a valid strobe) and compares it against two programmable comparator values, A and B. A 4-bit mode input picks one of nine ways of combining the two comparisons into a trigger. The modes are a single address, either address, a sequenced "A first, later B", an address match paired with a data byte match or mismatch, a repeating event on B with or without a preceding A, and inclusive in-range or out-of-range windows. While armed, the block raises a one-cycle trigger pulse for each qualifying bus cycle. It also flags whether that trigger should capture the bus data.

Each comparator can also require the bus direction to equal a programmed value. The per-comparator qualified match signals are always available to downstream trace and breakpoint logic, whether or not the block is armed. The sequencing flag for the "A then B" modes is visible as an output. It is cleared whenever the arm input is low.

Top module: `bus_trigger_eval`

## Requirements
- R1: While rstN is low, trigPulse, captureData, matchA, matchB and seqSeen are all 0.
- R2: A trigger is produced only for a bus cycle with busValid=1 while armEn=1. All outputs are registered, so each appears on the clock edge after the bus cycle that caused it.
- R3: Mode 0 triggers on a qualified A address match. Mode 1 triggers on a qualified A or a qualified B address match.
- R4: Mode 2 triggers on a qualified B match only when an earlier armed, valid cycle had a qualified A match. Any number of cycles may separate the two matches, and an A match in the same cycle does not count. seqSeen shows that an A match has been recorded.
- R5: seqSeen clears on the edge after any cycle with armEn=0. In modes 2 and 6, a B match that follows a disarm therefore does not trigger until a new A match is seen.
- R6: Mode 3 triggers when the address equals A and busData equals bits [7:0] of cmpBAddr in the same cycle. Bits [15:8] of cmpBAddr have no effect in this mode.
- R7: Mode 4 triggers when the address equals A and busData differs from bits [7:0] of cmpBAddr in the same cycle.
- R8: Mode 5 triggers on every qualified B address match, not only the first. Each such trigger also raises captureData.
- R9: Mode 6 behaves as mode 5, but only once a qualified A match has been recorded, as in R4. captureData goes high with every trigger.
- R10: Mode 7 triggers when cmpAAddr <= busAddr <= cmpBAddr (unsigned, both ends included).
- R11: Mode 8 triggers when busAddr < cmpAAddr or busAddr > cmpBAddr (unsigned).
- R12: With rwAEn=1, comparator A matches only when busRead equals rwAVal (busRead=1 means read). rwBEn and rwBVal do the same for comparator B. Modes 3 and 4 use only A's direction setting. Modes 7 and 8 require both settings to pass.
- R13: matchA and matchB report the qualified A and B address matches of each valid cycle, whatever the values of armEn and modeSel.
- R14: Mode codes 9 to 15 never trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armEn | input | 1 | Run enable; low clears the sequence flag |
| modeSel | input | 4 | Trigger mode code 0..8 |
| cmpAAddr | input | 16 | Comparator A address |
| cmpBAddr | input | 16 | Comparator B address; low byte is the data value in modes 3 and 4 |
| rwAEn | input | 1 | Enable direction check on comparator A |
| rwAVal | input | 1 | Direction required by comparator A (1 = read) |
| rwBEn | input | 1 | Enable direction check on comparator B |
| rwBVal | input | 1 | Direction required by comparator B (1 = read) |
| busValid | input | 1 | Bus cycle valid strobe |
| busAddr | input | 16 | Bus address |
| busData | input | 8 | Bus data byte |
| busRead | input | 1 | Bus direction, 1 = read |
| trigPulse | output | 1 | Qualified trigger, one cycle per event |
| captureData | output | 1 | Trigger asks for the data to be stored (modes 5, 6) |
| matchA | output | 1 | Qualified comparator A address match |
| matchB | output | 1 | Qualified comparator B address match |
| seqSeen | output | 1 | An A match has been recorded for sequenced modes |

## Verification
Every result comes out of a single register stage. A bus cycle presented before clock edge N shows up on trigPulse, captureData, matchA and matchB just after edge N. The sequence flag set by an A match takes effect for B matches presented from edge N+1 onward. The bench drives each vector shortly after a rising edge, waits for one rising edge, and then samples a few nanoseconds later. Each comparison therefore sees exactly the vector just applied, while the sequenced rows depend on the order of the rows before them.

// File: rtl/bus_trig_pkg.sv
package bus_trig_pkg;

  typedef enum logic [3:0] {
    MODE_A_ONLY       = 4'd0,
    MODE_A_OR_B       = 4'd1,
    MODE_A_THEN_B     = 4'd2,
    MODE_A_DATA       = 4'd3,
    MODE_A_NOT_DATA   = 4'd4,
    MODE_EVT_B        = 4'd5,
    MODE_A_THEN_EVT_B = 4'd6,
    MODE_IN_RANGE     = 4'd7,
    MODE_OUT_RANGE    = 4'd8
  } trigMode_e;

  localparam int NUM_CMP = 2;
  localparam int CMP_A   = 0;
  localparam int CMP_B   = 1;

  // Comparison results handed from datapath to control
  typedef struct packed {
    logic hitA;    // address equal A, direction ok
    logic hitB;    // address equal B, direction ok
    logic eqA;     // raw address equality on A
    logic dataEq;  // data byte equals low part of B
    logic geA;     // address >= A
    logic leB;     // address <= B
    logic rwOkA;
    logic rwOkB;
  } cmpHits_t;

  // Strobes from control back to the datapath output stage
  typedef struct packed {
    logic fire;
    logic capture;
  } ctlStrobes_t;

endpackage

// File: rtl/trig_addr_cmp.sv
module trig_addr_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] refAddr,
  input  logic              rwEn,
  input  logic              rwVal,
  input  logic              busRead,
  output logic              eq,
  output logic              ge,
  output logic              le,
  output logic              rwOk
);
  always_comb begin
    eq   = (addr == refAddr);
    ge   = (addr >= refAddr);
    le   = (addr <= refAddr);
    rwOk = !rwEn || (busRead == rwVal);
  end
endmodule

// File: rtl/trig_cmp_datapath.sv
module trig_cmp_datapath
  import bus_trig_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] cmpAAddr,
  input  logic [ADDR_W-1:0] cmpBAddr,
  input  logic              rwAEn,
  input  logic              rwAVal,
  input  logic              rwBEn,
  input  logic              rwBVal,
  input  ctlStrobes_t       strobes,
  output cmpHits_t          hits,
  output logic              trigPulse,
  output logic              captureData,
  output logic              matchA,
  output logic              matchB
);
  logic [ADDR_W-1:0] refArr [NUM_CMP];
  logic              rwEnArr [NUM_CMP];
  logic              rwValArr [NUM_CMP];
  logic              eqArr [NUM_CMP];
  logic              geArr [NUM_CMP];
  logic              leArr [NUM_CMP];
  logic              okArr [NUM_CMP];

  always_comb begin
    refArr[CMP_A]   = cmpAAddr;
    refArr[CMP_B]   = cmpBAddr;
    rwEnArr[CMP_A]  = rwAEn;
    rwEnArr[CMP_B]  = rwBEn;
    rwValArr[CMP_A] = rwAVal;
    rwValArr[CMP_B] = rwBVal;
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : gCmp
    trig_addr_cmp #(.ADDR_W(ADDR_W)) uCmp (
      .addr   (busAddr),
      .refAddr(refArr[gi]),
      .rwEn   (rwEnArr[gi]),
      .rwVal  (rwValArr[gi]),
      .busRead(busRead),
      .eq     (eqArr[gi]),
      .ge     (geArr[gi]),
      .le     (leArr[gi]),
      .rwOk   (okArr[gi])
    );
  end

  always_comb begin
    hits.eqA    = eqArr[CMP_A];
    hits.rwOkA  = okArr[CMP_A];
    hits.rwOkB  = okArr[CMP_B];
    hits.hitA   = eqArr[CMP_A] && okArr[CMP_A];
    hits.hitB   = eqArr[CMP_B] && okArr[CMP_B];
    hits.dataEq = (busData == cmpBAddr[DATA_W-1:0]);
    hits.geA    = geArr[CMP_A];
    hits.leB    = leArr[CMP_B];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPulse   <= 1'b0;
      captureData <= 1'b0;
      matchA      <= 1'b0;
      matchB      <= 1'b0;
    end else begin
      trigPulse   <= strobes.fire;
      captureData <= strobes.capture;
      matchA      <= busValid && hits.hitA;
      matchB      <= busValid && hits.hitB;
    end
  end
endmodule

// File: rtl/trig_mode_ctrl.sv
module trig_mode_ctrl
  import bus_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armEn,
  input  logic        busValid,
  input  logic [3:0]  modeSel,
  input  cmpHits_t    hits,
  output ctlStrobes_t strobes,
  output logic        seqSeen
);
  logic armedCycle;
  logic modeHit;
  logic captureMode;
  logic seqMode;

  always_comb begin
    armedCycle  = armEn && busValid;
    modeHit     = 1'b0;
    captureMode = 1'b0;
    seqMode     = 1'b0;
    case (modeSel)
      MODE_A_ONLY:     modeHit = hits.hitA;
      MODE_A_OR_B:     modeHit = hits.hitA || hits.hitB;
      MODE_A_THEN_B: begin
        seqMode = 1'b1;
        modeHit = hits.hitB && seqSeen;
      end
      MODE_A_DATA:     modeHit = hits.eqA && hits.dataEq && hits.rwOkA;
      MODE_A_NOT_DATA: modeHit = hits.eqA && !hits.dataEq && hits.rwOkA;
      MODE_EVT_B: begin
        captureMode = 1'b1;
        modeHit     = hits.hitB;
      end
      MODE_A_THEN_EVT_B: begin
        seqMode     = 1'b1;
        captureMode = 1'b1;
        modeHit     = hits.hitB && seqSeen;
      end
      MODE_IN_RANGE:
        modeHit = hits.geA && hits.leB && hits.rwOkA && hits.rwOkB;
      MODE_OUT_RANGE:
        modeHit = (!hits.geA || !hits.leB) && hits.rwOkA && hits.rwOkB;
      default: modeHit = 1'b0;
    endcase
    strobes.fire    = armedCycle && modeHit;
    strobes.capture = armedCycle && modeHit && captureMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqSeen <= 1'b0;
    end else if (!armEn) begin
      seqSeen <= 1'b0;
    end else if (armedCycle && seqMode && hits.hitA) begin
      seqSeen <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_trigger_eval.sv
module bus_trigger_eval
  import bus_trig_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armEn,
  input  logic [3:0]        modeSel,
  input  logic [ADDR_W-1:0] cmpAAddr,
  input  logic [ADDR_W-1:0] cmpBAddr,
  input  logic              rwAEn,
  input  logic              rwAVal,
  input  logic              rwBEn,
  input  logic              rwBVal,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRead,
  output logic              trigPulse,
  output logic              captureData,
  output logic              matchA,
  output logic              matchB,
  output logic              seqSeen
);
  cmpHits_t    hits;
  ctlStrobes_t strobes;

  trig_cmp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .busValid   (busValid),
    .busAddr    (busAddr),
    .busData    (busData),
    .busRead    (busRead),
    .cmpAAddr   (cmpAAddr),
    .cmpBAddr   (cmpBAddr),
    .rwAEn      (rwAEn),
    .rwAVal     (rwAVal),
    .rwBEn      (rwBEn),
    .rwBVal     (rwBVal),
    .strobes    (strobes),
    .hits       (hits),
    .trigPulse  (trigPulse),
    .captureData(captureData),
    .matchA     (matchA),
    .matchB     (matchB)
  );

  trig_mode_ctrl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .armEn   (armEn),
    .busValid(busValid),
    .modeSel (modeSel),
    .hits    (hits),
    .strobes (strobes),
    .seqSeen (seqSeen)
  );
endmodule

// File: rtl/trig_eval_checker.sv
module trig_eval_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              armEn,
  input logic              busValid,
  input logic [3:0]        modeSel,
  input logic [ADDR_W-1:0] busAddr,
  input logic [ADDR_W-1:0] cmpAAddr,
  input logic [ADDR_W-1:0] cmpBAddr,
  input logic              trigPulse,
  input logic              captureData,
  input logic              matchA,
  input logic              matchB,
  input logic              seqSeen
);
  assert_fire_needs_arm_R2: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(armEn && busValid));

  assert_match_needs_valid_R13: assert property (@(posedge clk) disable iff (!rstN)
    (matchA || matchB) |-> $past(busValid));

  assert_then_b_needs_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && $past(modeSel) == 4'd2) |-> $past(seqSeen));

  assert_seq_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(armEn) |-> !seqSeen);

  assert_capture_with_fire_R8: assert property (@(posedge clk) disable iff (!rstN)
    captureData |-> trigPulse);

  assert_inside_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && $past(modeSel) == 4'd7) |->
      $past(busAddr >= cmpAAddr && busAddr <= cmpBAddr));

  assert_reserved_silent_R14: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) > 4'd8) |-> !trigPulse);
endmodule

bind bus_trigger_eval trig_eval_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .armEn      (armEn),
  .busValid   (busValid),
  .modeSel    (modeSel),
  .busAddr    (busAddr),
  .cmpAAddr   (cmpAAddr),
  .cmpBAddr   (cmpBAddr),
  .trigPulse  (trigPulse),
  .captureData(captureData),
  .matchA     (matchA),
  .matchB     (matchB),
  .seqSeen    (seqSeen)
);

// File: tb/bus_trigger_eval_test.sv
module bus_trigger_eval_test;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  mode;
    logic        arm;
    logic        valid;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        rd;
    logic        rwAE;
    logic        rwAV;
    logic        rwBE;
    logic        rwBV;
    logic        expT;
    logic        expC;
    logic        expA;
    logic        expB;
  } vec_t;

  localparam int NV = 45;
  // A = 16'h1200, B = 16'h1280 for the whole table
  localparam vec_t TBL [NV] = '{
    '{4'd3,  4'd0,1,1,16'h1200,8'h00,1,0,0,0,0, 1,0,1,0}, // R3 A only hit
    '{4'd13, 4'd0,1,1,16'h1280,8'h00,1,0,0,0,0, 0,0,0,1}, // R13 B seen, no trig
    '{4'd2,  4'd0,1,0,16'h1200,8'h00,1,0,0,0,0, 0,0,0,0}, // R2 not valid
    '{4'd2,  4'd0,0,1,16'h1200,8'h00,1,0,0,0,0, 0,0,1,0}, // R2 disarmed, matchA stays
    '{4'd3,  4'd1,1,1,16'h1280,8'h00,1,0,0,0,0, 1,0,0,1}, // R3 A or B via B
    '{4'd3,  4'd1,1,1,16'h1201,8'h00,1,0,0,0,0, 0,0,0,0}, // R3 neither
    '{4'd5,  4'd2,0,0,16'h0000,8'h00,1,0,0,0,0, 0,0,0,0}, // R5 clear flag
    '{4'd4,  4'd2,1,1,16'h1280,8'h00,1,0,0,0,0, 0,0,0,1}, // R4 B before A
    '{4'd4,  4'd2,1,1,16'h1200,8'h00,1,0,0,0,0, 0,0,1,0}, // R4 A recorded
    '{4'd4,  4'd2,1,1,16'h0005,8'h00,1,0,0,0,0, 0,0,0,0}, // R4 gap
    '{4'd4,  4'd2,1,0,16'h1280,8'h00,1,0,0,0,0, 0,0,0,0}, // R4 invalid B
    '{4'd4,  4'd2,1,1,16'h1280,8'h00,1,0,0,0,0, 1,0,0,1}, // R4 B after A
    '{4'd4,  4'd2,1,1,16'h1280,8'h00,1,0,0,0,0, 1,0,0,1}, // R4 again
    '{4'd5,  4'd2,0,1,16'h0000,8'h00,1,0,0,0,0, 0,0,0,0}, // R5 disarm
    '{4'd5,  4'd2,1,1,16'h1280,8'h00,1,0,0,0,0, 0,0,0,1}, // R5 B needs new A
    '{4'd6,  4'd3,1,1,16'h1200,8'h80,1,0,0,0,0, 1,0,1,0}, // R6 addr+data
    '{4'd6,  4'd3,1,1,16'h1200,8'h81,1,0,0,0,0, 0,0,1,0}, // R6 data differs
    '{4'd6,  4'd3,1,1,16'h1280,8'h80,1,0,0,0,0, 0,0,0,1}, // R6 addr differs
    '{4'd7,  4'd4,1,1,16'h1200,8'h81,1,0,0,0,0, 1,0,1,0}, // R7 data mismatch
    '{4'd7,  4'd4,1,1,16'h1200,8'h80,1,0,0,0,0, 0,0,1,0}, // R7 data match
    '{4'd8,  4'd5,1,1,16'h1280,8'h00,1,0,0,0,0, 1,1,0,1}, // R8 event
    '{4'd8,  4'd5,1,1,16'h1280,8'h00,1,0,0,0,0, 1,1,0,1}, // R8 repeated
    '{4'd8,  4'd5,1,1,16'h1200,8'h00,1,0,0,0,0, 0,0,1,0}, // R8 A ignored
    '{4'd9,  4'd6,0,0,16'h0000,8'h00,1,0,0,0,0, 0,0,0,0}, // R9 clear
    '{4'd9,  4'd6,1,1,16'h1280,8'h00,1,0,0,0,0, 0,0,0,1}, // R9 B before A
    '{4'd9,  4'd6,1,1,16'h1200,8'h00,1,0,0,0,0, 0,0,1,0}, // R9 A
    '{4'd9,  4'd6,1,1,16'h1280,8'h00,1,0,0,0,0, 1,1,0,1}, // R9 event
    '{4'd9,  4'd6,1,1,16'h1280,8'h00,1,0,0,0,0, 1,1,0,1}, // R9 repeated
    '{4'd10, 4'd7,1,1,16'h11FF,8'h00,1,0,0,0,0, 0,0,0,0}, // R10 below
    '{4'd10, 4'd7,1,1,16'h1200,8'h00,1,0,0,0,0, 1,0,1,0}, // R10 low edge
    '{4'd10, 4'd7,1,1,16'h1240,8'h00,1,0,0,0,0, 1,0,0,0}, // R10 middle
    '{4'd10, 4'd7,1,1,16'h1280,8'h00,1,0,0,0,0, 1,0,0,1}, // R10 high edge
    '{4'd10, 4'd7,1,1,16'h1281,8'h00,1,0,0,0,0, 0,0,0,0}, // R10 above
    '{4'd11, 4'd8,1,1,16'h11FF,8'h00,1,0,0,0,0, 1,0,0,0}, // R11 below
    '{4'd11, 4'd8,1,1,16'h1200,8'h00,1,0,0,0,0, 0,0,1,0}, // R11 low edge
    '{4'd11, 4'd8,1,1,16'h1280,8'h00,1,0,0,0,0, 0,0,0,1}, // R11 high edge
    '{4'd11, 4'd8,1,1,16'h1281,8'h00,1,0,0,0,0, 1,0,0,0}, // R11 above
    '{4'd12, 4'd0,1,1,16'h1200,8'h00,1,1,0,0,0, 0,0,0,0}, // R12 A wants write
    '{4'd12, 4'd0,1,1,16'h1200,8'h00,0,1,0,0,0, 1,0,1,0}, // R12 write ok
    '{4'd12, 4'd1,1,1,16'h1280,8'h00,1,0,0,1,1, 1,0,0,1}, // R12 B wants read
    '{4'd12, 4'd1,1,1,16'h1280,8'h00,0,0,0,1,1, 0,0,0,0}, // R12 B wrong dir
    '{4'd12, 4'd3,1,1,16'h1200,8'h80,1,0,0,1,0, 1,0,1,0}, // R12 full mode ignores B dir
    '{4'd12, 4'd3,1,1,16'h1200,8'h80,1,1,0,0,0, 0,0,0,0}, // R12 full mode A dir
    '{4'd14, 4'd9,1,1,16'h1200,8'h00,1,0,0,0,0, 0,0,1,0}, // R14 code 9
    '{4'd14, 4'd15,1,1,16'h1280,8'h00,1,0,0,0,0, 0,0,0,1} // R14 code 15
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armEn = 1'b0;
  logic [3:0]  modeSel = 4'd0;
  logic [15:0] cmpAAddr = 16'h1200;
  logic [15:0] cmpBAddr = 16'h1280;
  logic        rwAEn = 1'b0, rwAVal = 1'b0, rwBEn = 1'b0, rwBVal = 1'b0;
  logic        busValid = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic [7:0]  busData = 8'h00;
  logic        busRead = 1'b1;
  logic        trigPulse, captureData, matchA, matchB, seqSeen;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_trigger_eval uut (
    .clk(clk), .rstN(rstN), .armEn(armEn), .modeSel(modeSel),
    .cmpAAddr(cmpAAddr), .cmpBAddr(cmpBAddr),
    .rwAEn(rwAEn), .rwAVal(rwAVal), .rwBEn(rwBEn), .rwBVal(rwBVal),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busRead(busRead),
    .trigPulse(trigPulse), .captureData(captureData),
    .matchA(matchA), .matchB(matchB), .seqSeen(seqSeen)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic a, input logic v,
                       input logic [15:0] ad, input logic [7:0] d, input logic r);
    modeSel = m; armEn = a; busValid = v; busAddr = ad; busData = d; busRead = r;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    // R1: matching inputs while in reset, outputs must stay low
    drive(4'd0, 1'b1, 1'b1, 16'h1200, 8'h00, 1'b1);
    step();
    step();
    check("R1", "trigPulse", trigPulse, 1'b0);
    check("R1", "captureData", captureData, 1'b0);
    check("R1", "matchA", matchA, 1'b0);
    check("R1", "matchB", matchB, 1'b0);
    check("R1", "seqSeen", seqSeen, 1'b0);
    drive(4'd0, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1);
    rstN = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = TBL[i];
      rwAEn = v.rwAE; rwAVal = v.rwAV; rwBEn = v.rwBE; rwBVal = v.rwBV;
      drive(v.mode, v.arm, v.valid, v.addr, v.data, v.rd);
      step();
      tag = $sformatf("R%0d row%0d", v.req, i);
      check(tag, "trigPulse", trigPulse, v.expT);
      check(tag, "captureData", captureData, v.expC);
      check(tag, "matchA", matchA, v.expA);
      check(tag, "matchB", matchB, v.expB);
    end
    rwAEn = 1'b0; rwBEn = 1'b0;

    // R4 / R5: sequence flag visible, then cleared by disarm
    drive(4'd2, 1'b1, 1'b1, 16'h1200, 8'h00, 1'b1);
    step();
    check("R4", "seqSeen after A", seqSeen, 1'b1);
    drive(4'd2, 1'b1, 1'b1, 16'h1280, 8'h00, 1'b1);
    step();
    check("R4", "seqSeen held", seqSeen, 1'b1);
    drive(4'd2, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1);
    step();
    check("R5", "seqSeen after disarm", seqSeen, 1'b0);

    // R6: high byte of B is not part of the data compare
    cmpBAddr = 16'h5580;
    drive(4'd3, 1'b1, 1'b1, 16'h1200, 8'h80, 1'b1);
    step();
    check("R6", "B high byte ignored", trigPulse, 1'b1);

    // R10: single-point window A == B
    cmpAAddr = 16'h1234; cmpBAddr = 16'h1234;
    drive(4'd7, 1'b1, 1'b1, 16'h1234, 8'h00, 1'b1);
    step();
    check("R10", "A==B window hit", trigPulse, 1'b1);
    drive(4'd7, 1'b1, 1'b1, 16'h1235, 8'h00, 1'b1);
    step();
    check("R10", "A==B window miss", trigPulse, 1'b0);

    // R11: full-span window, nothing is outside
    cmpAAddr = 16'h0000; cmpBAddr = 16'hFFFF;
    drive(4'd8, 1'b1, 1'b1, 16'h0000, 8'h00, 1'b1);
    step();
    check("R11", "min address not outside", trigPulse, 1'b0);
    drive(4'd8, 1'b1, 1'b1, 16'hFFFF, 8'h00, 1'b1);
    step();
    check("R11", "max address not outside", trigPulse, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule